// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Victim Buffer

This block is a 1 KB direct-mapped data cache with 32-byte lines. Behind it sits a four-entry, fully associative buffer that holds lines recently pushed out of the main array. A processor issues word reads and writes through a request port. The cache answers a hit in the same cycle. On a miss it raises `stall`, and the processor keeps its request steady until the hit is reported.

When the main array misses, the controller searches the victim buffer in the next cycle. If a victim entry matches, the two lines trade places and no memory traffic occurs. If nothing matches, the displaced line is pushed into the victim buffer and a whole line is fetched from memory over a request/response interface. The memory side carries no write-back traffic.

The controller has three states:
- `ST_LOOK` is the lookup state.
- `ST_PROBE` is the victim search.
- `ST_FILL` waits for the memory line.

It moves through these transitions:
- Look-miss goes from `ST_LOOK` to `ST_PROBE`.
- Probe-hit (swap) goes from `ST_PROBE` to `ST_LOOK`.
- Probe-miss (evict and fetch) goes from `ST_PROBE` to `ST_FILL`.
- Fill-done goes from `ST_FILL` to `ST_LOOK` when the response arrives.

Top module: `dm_victim_cache`

## Requirements
- R1: Reset invalidates every line of the main array and every victim entry. After reset, with no request, `stall`, `rsp_hit` and `mem_req` are 0, and the first access to any line fetches it from memory.
- R2: The address is split as follows. Bits [31:10] are the tag. Bits [9:5] select one of 32 lines. Bits [4:2] select one of eight 32-bit words in the line. A memory fetch presents bits [31:5] on `mem_addr`. A fetched line carries word w of the block in bits [32w+31:32w].
- R3: A lookup hits only when the selected line is valid and its stored tag equals the address tag. A hit gives `rsp_hit`=1, `stall`=0 and the word on `rsp_rdata` in the cycle the request is presented.
- R4: A main-array miss raises `stall` at once, and the next cycle is the victim search. A main-array hit never searches the victim buffer.
- R5: Victim entries keep the full block address (tag and index). They match a request only on that whole address, so a line with the same index but another tag does not match. No two valid entries hold the same block.
- R6: A victim hit swaps that entry with the main-array line of the same index, with no memory request. The request is answered in its third cycle.
- R7: When both structures miss, `mem_req` rises in the third cycle and stays high with `mem_addr` steady until `mem_rsp_valid`. The line is then written, and the request hits in the cycle after the response.
- R8: A write that hits replaces the selected word. A write that misses first brings the line in, then writes the word; the other words keep their fetched values.
- R9: After a swap, the line that left the main array stays in the victim buffer and can be swapped back without memory traffic.
- R10: On a double miss, a valid main-array line is pushed into the slot of the least recently pushed entry, overwriting it. Swaps do not change that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present; held until hit |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address of the word |
| req_wdata | input | 32 | Write data |
| rsp_hit | output | 1 | Request served this cycle |
| rsp_rdata | output | 32 | Read data, valid with `rsp_hit` |
| stall | output | 1 | Request not yet served |
| mem_req | output | 1 | Line fetch request |
| mem_addr | output | 27 | Block address of the fetch |
| mem_rsp_valid | input | 1 | Fetched line present |
| mem_rsp_line | input | 256 | Fetched line, word 0 in the low bits |

## Verification
The bench first walks all 32 indices cold and then warm, which separates fetch latency from same-cycle hits and checks the index and word-select split at every line. Conflict sweeps with a second and third tag on the same indices then fill the victim buffer past its depth. From the count of cycles and memory fetches, the bench tells a swap from a fetch and shows that the oldest pushed line is the one lost. A word written before its line is displaced must come back after two swaps, which proves that swaps move data rather than refetch it. A same-index, different-tag probe shows that victim matching uses the whole block address.

// File: rtl/dmv_pkg.sv
package dmv_pkg;
    typedef enum logic [1:0] {
        ST_LOOK  = 2'd0,
        ST_PROBE = 2'd1,
        ST_FILL  = 2'd2
    } dmv_state_t;
endpackage

// File: rtl/dmv_main_array.sv
module dmv_main_array #(
    parameter int IDX_W  = 5,
    parameter int TAG_W  = 22,
    parameter int WORD_W = 32,
    parameter int WSEL_W = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [IDX_W-1:0]                  idx,
    output logic                              rd_valid,
    output logic [TAG_W-1:0]                  rd_tag,
    output logic [(WORD_W<<WSEL_W)-1:0]       rd_line,
    input  logic                              line_we,
    input  logic [TAG_W-1:0]                  line_tag,
    input  logic [(WORD_W<<WSEL_W)-1:0]       line_data,
    input  logic                              word_we,
    input  logic [WSEL_W-1:0]                 word_sel,
    input  logic [WORD_W-1:0]                 word_data
);
    localparam int LINES  = 1 << IDX_W;
    localparam int LINE_W = WORD_W << WSEL_W;

    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [LINE_W-1:0] data_q [LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (line_we) begin
            valid_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (line_we) begin
            tag_q[idx]  <= line_tag;
            data_q[idx] <= line_data;
        end else if (word_we) begin
            data_q[idx][word_sel*WORD_W +: WORD_W] <= word_data;
        end
    end

    assign rd_valid = valid_q[idx];
    assign rd_tag   = tag_q[idx];
    assign rd_line  = data_q[idx];
endmodule

// File: rtl/dmv_victim_buf.sv
module dmv_victim_buf #(
    parameter int N      = 4,
    parameter int BA_W   = 27,
    parameter int LINE_W = 256
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [BA_W-1:0]           look_ba,
    output logic                      hit,
    output logic [N-1:0]              match,
    output logic [LINE_W-1:0]         hit_line,
    input  logic                      swap_we,
    input  logic                      push_we,
    input  logic                      wr_valid,
    input  logic [BA_W-1:0]           wr_ba,
    input  logic [LINE_W-1:0]         wr_line
);
    localparam int P_W = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0]      valid_q;
    logic [BA_W-1:0]   ba_q   [N];
    logic [LINE_W-1:0] line_q [N];
    logic [P_W-1:0]    ptr_q;
    logic [P_W-1:0]    hit_slot;
    logic [P_W-1:0]    wr_slot;

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match[g] = valid_q[g] && (ba_q[g] == look_ba);
    end

    always_comb begin
        hit_slot = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (match[i]) hit_slot = P_W'(i);
        end
    end

    assign hit      = |match;
    assign hit_line = line_q[hit_slot];
    assign wr_slot  = swap_we ? hit_slot : ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            ptr_q   <= '0;
        end else begin
            if (swap_we || push_we) valid_q[wr_slot] <= wr_valid;
            if (push_we) ptr_q <= (ptr_q == P_W'(N - 1)) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (swap_we || push_we) begin
            ba_q[wr_slot]   <= wr_ba;
            line_q[wr_slot] <= wr_line;
        end
    end
endmodule

// File: rtl/dmv_ctrl.sv
module dmv_ctrl
    import dmv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       main_hit,
    input  logic       vb_hit,
    input  logic       rsp_valid,
    output dmv_state_t state,
    output logic       do_swap,
    output logic       do_evict,
    output logic       do_fill,
    output logic       fetch,
    output logic       busy
);
    dmv_state_t nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LOOK;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_LOOK:  if (req_valid && !main_hit) nxt = ST_PROBE;
            ST_PROBE: nxt = vb_hit ? ST_LOOK : ST_FILL;
            ST_FILL:  if (rsp_valid) nxt = ST_LOOK;
            default:  nxt = ST_LOOK;
        endcase
    end

    always_comb begin
        do_swap  = 1'b0;
        do_evict = 1'b0;
        do_fill  = 1'b0;
        fetch    = 1'b0;
        busy     = 1'b1;
        unique case (state)
            ST_LOOK:  busy = 1'b0;
            ST_PROBE: begin
                do_swap  = vb_hit;
                do_evict = !vb_hit;
            end
            ST_FILL: begin
                fetch   = 1'b1;
                do_fill = rsp_valid;
            end
            default: busy = 1'b0;
        endcase
    end
endmodule

// File: rtl/dm_victim_cache.sv
module dm_victim_cache
    import dmv_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFFS_W = 5,
    parameter int IDX_W  = 5,
    parameter int WORD_W = 32,
    parameter int VB_N   = 4
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 req_valid,
    input  logic                                 req_we,
    input  logic [ADDR_W-1:0]                    req_addr,
    input  logic [WORD_W-1:0]                    req_wdata,
    output logic                                 rsp_hit,
    output logic [WORD_W-1:0]                    rsp_rdata,
    output logic                                 stall,
    output logic                                 mem_req,
    output logic [ADDR_W-OFFS_W-1:0]             mem_addr,
    input  logic                                 mem_rsp_valid,
    input  logic [(8<<OFFS_W)-1:0]               mem_rsp_line
);
    localparam int BOFF_W = $clog2(WORD_W / 8);
    localparam int WSEL_W = OFFS_W - BOFF_W;
    localparam int TAG_W  = ADDR_W - IDX_W - OFFS_W;
    localparam int BA_W   = ADDR_W - OFFS_W;
    localparam int LINE_W = 8 << OFFS_W;

    logic [TAG_W-1:0]  req_tag;
    logic [IDX_W-1:0]  req_idx;
    logic [WSEL_W-1:0] req_wsel;
    logic [BA_W-1:0]   req_ba;

    assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
    assign req_idx  = req_addr[OFFS_W +: IDX_W];
    assign req_wsel = req_addr[BOFF_W +: WSEL_W];
    assign req_ba   = req_addr[ADDR_W-1:OFFS_W];

    logic              rd_valid;
    logic [TAG_W-1:0]  rd_tag;
    logic [LINE_W-1:0] rd_line;
    logic              main_hit;
    logic              vb_hit;
    logic [VB_N-1:0]   vb_match;
    logic [LINE_W-1:0] vb_line;
    dmv_state_t        st;
    logic              do_swap, do_evict, do_fill, busy;

    assign main_hit = rd_valid && (rd_tag == req_tag);

    dmv_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .main_hit  (main_hit),
        .vb_hit    (vb_hit),
        .rsp_valid (mem_rsp_valid),
        .state     (st),
        .do_swap   (do_swap),
        .do_evict  (do_evict),
        .do_fill   (do_fill),
        .fetch     (mem_req),
        .busy      (busy)
    );

    dmv_main_array #(
        .IDX_W (IDX_W), .TAG_W (TAG_W), .WORD_W (WORD_W), .WSEL_W (WSEL_W)
    ) u_main (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (req_idx),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_line   (rd_line),
        .line_we   (do_swap || do_fill),
        .line_tag  (req_tag),
        .line_data (do_swap ? vb_line : mem_rsp_line),
        .word_we   (rsp_hit && req_we),
        .word_sel  (req_wsel),
        .word_data (req_wdata)
    );

    dmv_victim_buf #(
        .N (VB_N), .BA_W (BA_W), .LINE_W (LINE_W)
    ) u_vbuf (
        .clk      (clk),
        .rst_n    (rst_n),
        .look_ba  (req_ba),
        .hit      (vb_hit),
        .match    (vb_match),
        .hit_line (vb_line),
        .swap_we  (do_swap),
        .push_we  (do_evict && rd_valid),
        .wr_valid (rd_valid),
        .wr_ba    ({rd_tag, req_idx}),
        .wr_line  (rd_line)
    );

    assign rsp_hit   = !busy && req_valid && main_hit;
    assign stall     = busy || (req_valid && !main_hit);
    assign rsp_rdata = rd_line[req_wsel*WORD_W +: WORD_W];
    assign mem_addr  = req_ba;
endmodule

// File: rtl/dmv_checker.sv
module dmv_checker
    import dmv_pkg::*;
#(
    parameter int N    = 4,
    parameter int BA_W = 27
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic            rsp_hit,
    input logic            stall,
    input logic            mem_req,
    input logic [BA_W-1:0] mem_addr,
    input logic            mem_rsp_valid,
    input logic            main_hit,
    input logic            vb_hit,
    input logic [N-1:0]    vb_match,
    input dmv_state_t      st
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOOK) |-> !mem_req);

    assert_hit_no_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> !stall);

    assert_miss_probes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOOK && req_valid && !main_hit) |=> (st == ST_PROBE));

    assert_hit_no_probe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOOK && req_valid && main_hit) |=> (st == ST_LOOK));

    assert_unique_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vb_match));

    assert_swap_no_mem_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PROBE && vb_hit) |=> (st == ST_LOOK && !mem_req));

    assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rsp_valid) |=> (mem_req && $stable(mem_addr)));

    assert_fill_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_rsp_valid) |=> !mem_req);
endmodule

bind dm_victim_cache dmv_checker #(.N(VB_N), .BA_W(ADDR_W - OFFS_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .rsp_hit       (rsp_hit),
    .stall         (stall),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .main_hit      (main_hit),
    .vb_hit        (vb_hit),
    .vb_match      (vb_match),
    .st            (st)
);

// File: tb/sim_dm_victim_cache.sv
module sim_dm_victim_cache;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_we = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [31:0]  req_wdata = '0;
    logic         rsp_hit;
    logic [31:0]  rsp_rdata;
    logic         stall;
    logic         mem_req;
    logic [26:0]  mem_addr;
    logic         mem_rsp_valid = 1'b0;
    logic [255:0] mem_rsp_line = '0;

    int errors = 0;
    int checks = 0;
    int refills = 0;
    int lat = 0;
    logic [26:0] last_ba = '0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dm_victim_cache u0 (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_we (req_we),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .rsp_hit (rsp_hit), .rsp_rdata (rsp_rdata), .stall (stall),
        .mem_req (mem_req), .mem_addr (mem_addr),
        .mem_rsp_valid (mem_rsp_valid), .mem_rsp_line (mem_rsp_line)
    );

    // Memory model: word w of block b holds the byte address {b, w, 2'b00}
    function automatic logic [255:0] mkline(input logic [26:0] b);
        logic [255:0] l;
        for (int w = 0; w < 8; w++) l[w*32 +: 32] = {b, 3'(w), 2'b00};
        return l;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rsp_valid <= 1'b0;
            lat <= 0;
        end else if (mem_rsp_valid) begin
            mem_rsp_valid <= 1'b0;
        end else if (mem_req) begin
            if (lat == 1) begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_line  <= mkline(mem_addr);
                last_ba       <= mem_addr;
                refills       <= refills + 1;
                lat           <= 0;
            end else begin
                lat <= lat + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // exp_cyc: 1 = hit, 3 = victim swap, 6 = memory fetch
    task automatic acc(input logic [31:0] a, input logic we, input logic [31:0] wd,
                       input int exp_cyc, input logic [31:0] exp_d, input string rq);
        int cyc;
        int r0;
        r0 = refills;
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
        cyc = 1;
        #1;
        while (stall && cyc < 40) begin
            @(negedge clk); #1; cyc++;
        end
        chk(cyc == exp_cyc, rq, "cycles", cyc, exp_cyc);
        chk(rsp_hit == 1'b1, rq, "rsp_hit", rsp_hit, 1);
        if (!we) chk(rsp_rdata == exp_d, rq, "rdata", rsp_rdata, exp_d);
        chk((refills - r0) == ((exp_cyc == 6) ? 1 : 0), rq, "fetches", refills - r0,
            (exp_cyc == 6) ? 1 : 0);
        if (exp_cyc == 6) chk(last_ba == a[31:5], rq, "mem_addr", last_ba, a[31:5]);
        @(posedge clk); #1;
        req_valid = 1'b0; req_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", 0, 1);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: idle after reset
        chk(stall == 1'b0, "R1", "stall", stall, 0);
        chk(rsp_hit == 1'b0, "R1", "rsp_hit", rsp_hit, 0);
        chk(mem_req == 1'b0, "R1", "mem_req", mem_req, 0);

        // R1 R2 R7: cold sweep over every index, each fetched from memory
        for (int i = 0; i < 32; i++) begin
            acc(32'(i * 32 + (i % 8) * 4), 1'b0, '0, 6, 32'(i * 32 + (i % 8) * 4), "R7");
        end
        // R3 R4: warm sweep, other word of each line, same-cycle hit
        for (int i = 0; i < 32; i++) begin
            acc(32'(i * 32 + ((i + 3) % 8) * 4), 1'b0, '0, 1, 32'(i * 32 + ((i + 3) % 8) * 4), "R3");
        end
        // R8: write hit then read back
        acc(32'h74, 1'b1, 32'hCAFE0074, 1, '0, "R8");
        acc(32'h74, 1'b0, '0, 1, 32'hCAFE0074, "R8");
        acc(32'h70, 1'b0, '0, 1, 32'h70, "R8");
        // R10: six conflicts through a four-entry buffer
        for (int i = 0; i < 6; i++) begin
            acc(32'h400 + 32'(i * 32), 1'b0, '0, 6, 32'h400 + 32'(i * 32), "R10");
        end
        acc(32'h0, 1'b0, '0, 6, 32'h0, "R10");            // oldest entry was lost
        // R6: swap back the written line
        acc(32'h74, 1'b0, '0, 3, 32'hCAFE0074, "R6");
        // R9: displaced line returns by swap, then the written one again
        acc(32'h460, 1'b0, '0, 3, 32'h460, "R9");
        acc(32'h74, 1'b0, '0, 3, 32'hCAFE0074, "R9");
        acc(32'h40, 1'b0, '0, 6, 32'h40, "R10");           // overwritten in buffer
        acc(32'h80, 1'b0, '0, 3, 32'h80, "R6");
        acc(32'h440, 1'b0, '0, 3, 32'h440, "R6");
        acc(32'h460, 1'b0, '0, 6, 32'h460, "R10");
        // R5: same index, different tag must not match a victim entry
        acc(32'h8E0, 1'b0, '0, 6, 32'h8E0, "R5");
        acc(32'h4E0, 1'b0, '0, 6, 32'h4E0, "R5");
        acc(32'hE0, 1'b0, '0, 3, 32'hE0, "R5");
        // R8: write miss allocates, then writes one word
        acc(32'h948, 1'b1, 32'h12345678, 6, '0, "R8");
        acc(32'h948, 1'b0, '0, 1, 32'h12345678, "R8");
        acc(32'h94C, 1'b0, '0, 1, 32'h94C, "R8");
        // R2: high tag bits reach mem_addr
        acc(32'hFFFFFC24, 1'b0, '0, 6, 32'hFFFFFC24, "R2");

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule